// File: doc/BRIEF.md
# Granule Protection Checker

This block decides whether an access to a physical address in a chosen physical address space may go ahead. It assumes that the protection table entry for the granule has already been fetched. The caller presents the address, the target physical space and the security state of the requester. It also presents a control word, the table base value, a mask of the protected physical size, a feature strap and the 4-bit protection code of the granule.

One cycle after a request the block returns a registered verdict. The verdict is either "no fault" or one of three fault classes: fail, size or walk.

The checks have a fixed precedence, and only the first one that decides the outcome is reported:

1. The per-space disable bits.
2. The address-range check, which can end the check early with a pass.
3. The table-base range check.
4. The decode of the protection code.

Alongside the verdict, the block returns the level-0 table size derived from the control word, for use by an external table walker.

Top module: `gpc_unit`

## Requirements
- R1: After reset, rspValid is 0 and rspFault is 2'b00. The fault code values are 00 none, 01 fail, 10 size and 11 walk.
- R2: A request sampled with reqValid high gives rspValid high on the following cycle. With reqValid low, rspValid is low on the next cycle, and rspFault and rspL0Size keep their last values.
- R3: Space codes are 0 secure, 1 non-secure, 2 root and 3 realm. The disable bits sit in ctrlReg: bit 0 for secure, bit 1 for non-secure and bit 2 for realm. If the bit for the target space is set, the result is fail, whatever the later checks would say. Root has no disable bit.
- R4: An address with any bit set outside ppsMask passes with no fault when the target space is non-secure or when ctrlReg bit 3 (outside exemption) is set. Otherwise it fails. In both cases no later check applies.
- R5: If the address is inside the mask but {tableBase, 12'b0} has a bit outside ppsMask, the result is size.
- R6: Protection code 4'b1111 passes for every space.
- R7: Codes 4'b1000 to 4'b1011 pass only when the target space equals the low two bits of the code. Otherwise they fail.
- R8: Code 4'b1000 gives walk when secEl2Present is low.
- R9: Code 4'b1101 gives walk when ctrlReg bit 4 (non-secure-only enable) is clear. When that bit is set, the code passes only for target space non-secure with a requester state of non-secure or root, and fails otherwise.
- R10: Every other protection code gives walk.
- R11: rspL0Size equals 30 plus ctrlReg[11:8], registered with the verdict.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| reqValid | input | 1 | Request strobe |
| reqAddr | input | PA_W | Physical address to check |
| reqSpace | input | 2 | Target physical address space |
| reqSecState | input | 2 | Security state of the requester |
| ctrlReg | input | 16 | Control word (disable, exemption, enable and size fields) |
| tableBase | input | PA_W-12 | Table base in granule units |
| ppsMask | input | PA_W | Mask of the protected physical size |
| secEl2Present | input | 1 | Feature strap that validates the secure code |
| gpi | input | 4 | Protection code for the granule |
| rspValid | output | 1 | Result valid |
| rspFault | output | 2 | Fault class of the result |
| rspL0Size | output | 6 | Level-0 table size |

## Verification
Each verdict passes through a single register. A wrong precedence or a bad decode therefore shows up on rspFault one cycle after the request that exposed it, with no state carried into later requests.

The directed cases pair an earlier-priority condition with a later one that would give a different code. Any reordering of the checks then changes the visible fault class. Idle cycles with changing inputs show whether the held result is disturbed when no request is present.

// File: rtl/gpc_pkg.sv
package gpc_pkg;
  typedef enum logic [1:0] {
    SP_SECURE    = 2'd0,
    SP_NONSECURE = 2'd1,
    SP_ROOT      = 2'd2,
    SP_REALM     = 2'd3
  } space_e;

  typedef enum logic [1:0] {
    FLT_NONE = 2'd0,
    FLT_FAIL = 2'd1,
    FLT_SIZE = 2'd2,
    FLT_WALK = 2'd3
  } fault_e;

  localparam int CTRL_W       = 16;
  localparam int BIT_SEC_OFF  = 0;
  localparam int BIT_NS_OFF   = 1;
  localparam int BIT_RLM_OFF  = 2;
  localparam int BIT_EXEMPT   = 3;
  localparam int BIT_NSONLY   = 4;
  localparam int L0_LO        = 8;
  localparam int L0_FIELD_W   = 4;
  localparam int L0_BASE      = 30;
  localparam int L0_W         = 6;
  localparam int NUM_SPACES   = 4;

  typedef struct packed {
    logic   spaceOff;
    logic   addrOut;
    logic   outExempt;
    logic   baseOut;
    fault_e gpiVerdict;
  } flags_t;

  typedef struct packed {
    logic   load;
    fault_e fault;
  } strobe_t;
endpackage

// File: rtl/gpc_datapath.sv
module gpc_datapath
  import gpc_pkg::*;
#(
  parameter int PA_W = 48,
  parameter int GRANULE_SHIFT = 12,
  localparam int BASE_W = PA_W - GRANULE_SHIFT
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [PA_W-1:0]   reqAddr,
  input  logic [1:0]        reqSpace,
  input  logic [1:0]        reqSecState,
  input  logic [CTRL_W-1:0] ctrlReg,
  input  logic [BASE_W-1:0] tableBase,
  input  logic [PA_W-1:0]   ppsMask,
  input  logic              secEl2Present,
  input  logic [3:0]        gpi,
  input  strobe_t           strobe,
  output flags_t            flags,
  output logic              rspValid,
  output logic [1:0]        rspFault,
  output logic [L0_W-1:0]   rspL0Size
);
  logic [NUM_SPACES-1:0] disableVec;
  logic [PA_W-1:0]       baseAddr;
  fault_e                gpiVerdict;
  space_e                tgtSpace;
  space_e                srcState;

  assign tgtSpace = space_e'(reqSpace);
  assign srcState = space_e'(reqSecState);
  assign baseAddr = {tableBase, {GRANULE_SHIFT{1'b0}}};

  for (genvar s = 0; s < NUM_SPACES; s++) begin : g_disable
    if (s == int'(SP_SECURE)) begin : g_sec
      assign disableVec[s] = ctrlReg[BIT_SEC_OFF];
    end else if (s == int'(SP_NONSECURE)) begin : g_ns
      assign disableVec[s] = ctrlReg[BIT_NS_OFF];
    end else if (s == int'(SP_REALM)) begin : g_rlm
      assign disableVec[s] = ctrlReg[BIT_RLM_OFF];
    end else begin : g_root
      assign disableVec[s] = 1'b0;
    end
  end

  always_comb begin
    gpiVerdict = FLT_WALK;
    unique case (gpi)
      4'b1111: gpiVerdict = FLT_NONE;
      4'b1000: begin
        if (!secEl2Present) gpiVerdict = FLT_WALK;
        else gpiVerdict = (reqSpace == gpi[1:0]) ? FLT_NONE : FLT_FAIL;
      end
      4'b1001, 4'b1010, 4'b1011:
        gpiVerdict = (reqSpace == gpi[1:0]) ? FLT_NONE : FLT_FAIL;
      4'b1101: begin
        if (!ctrlReg[BIT_NSONLY]) gpiVerdict = FLT_WALK;
        else if (tgtSpace == SP_NONSECURE &&
                 (srcState == SP_NONSECURE || srcState == SP_ROOT))
          gpiVerdict = FLT_NONE;
        else gpiVerdict = FLT_FAIL;
      end
      default: gpiVerdict = FLT_WALK;
    endcase
  end

  assign flags.spaceOff   = disableVec[reqSpace];
  assign flags.addrOut    = |(reqAddr & ~ppsMask);
  assign flags.outExempt  = (tgtSpace == SP_NONSECURE) || ctrlReg[BIT_EXEMPT];
  assign flags.baseOut    = |(baseAddr & ~ppsMask);
  assign flags.gpiVerdict = gpiVerdict;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rspValid  <= 1'b0;
      rspFault  <= FLT_NONE;
      rspL0Size <= '0;
    end else begin
      rspValid <= strobe.load;
      if (strobe.load) begin
        rspFault  <= strobe.fault;
        rspL0Size <= L0_W'(L0_BASE) + L0_W'(ctrlReg[L0_LO +: L0_FIELD_W]);
      end
    end
  end

  assert_hold_idle_R2: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.load |=> ($stable(rspFault) && $stable(rspL0Size)));
endmodule

// File: rtl/gpc_ctrl.sv
module gpc_ctrl
  import gpc_pkg::*;
(
  input  logic    reqValid,
  input  flags_t  flags,
  output strobe_t strobe
);
  always_comb begin
    strobe.load = reqValid;
    if (flags.spaceOff)
      strobe.fault = FLT_FAIL;
    else if (flags.addrOut)
      strobe.fault = flags.outExempt ? FLT_NONE : FLT_FAIL;
    else if (flags.baseOut)
      strobe.fault = FLT_SIZE;
    else
      strobe.fault = flags.gpiVerdict;
  end
endmodule

// File: rtl/gpc_unit.sv
module gpc_unit
  import gpc_pkg::*;
#(
  parameter int PA_W = 48,
  parameter int GRANULE_SHIFT = 12,
  localparam int BASE_W = PA_W - GRANULE_SHIFT
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [PA_W-1:0]   reqAddr,
  input  logic [1:0]        reqSpace,
  input  logic [1:0]        reqSecState,
  input  logic [15:0]       ctrlReg,
  input  logic [BASE_W-1:0] tableBase,
  input  logic [PA_W-1:0]   ppsMask,
  input  logic              secEl2Present,
  input  logic [3:0]        gpi,
  output logic              rspValid,
  output logic [1:0]        rspFault,
  output logic [5:0]        rspL0Size
);
  flags_t  flags;
  strobe_t strobe;

  gpc_datapath #(.PA_W(PA_W), .GRANULE_SHIFT(GRANULE_SHIFT)) i_datapath (
    .clk(clk), .rstN(rstN), .reqAddr(reqAddr), .reqSpace(reqSpace),
    .reqSecState(reqSecState), .ctrlReg(ctrlReg), .tableBase(tableBase),
    .ppsMask(ppsMask), .secEl2Present(secEl2Present), .gpi(gpi),
    .strobe(strobe), .flags(flags), .rspValid(rspValid),
    .rspFault(rspFault), .rspL0Size(rspL0Size)
  );

  gpc_ctrl i_ctrl (.reqValid(reqValid), .flags(flags), .strobe(strobe));

  assert_valid_follows_R2: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |=> rspValid);
  assert_valid_idle_R2: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |=> !rspValid);
  assert_sec_disable_R3: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqSpace == 2'd0 && ctrlReg[0]) |=> rspFault == 2'd1);
  assert_ns_outside_pass_R4: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqSpace == 2'd1 && !ctrlReg[1] && |(reqAddr & ~ppsMask))
      |=> rspFault == 2'd0);
  assert_root_all_access_R6: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqSpace == 2'd2 && gpi == 4'hF && !(|(reqAddr & ~ppsMask)) &&
     !(|({tableBase, {GRANULE_SHIFT{1'b0}}} & ~ppsMask))) |=> rspFault == 2'd0);
  assert_l0_size_R11: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |=> rspL0Size == 6'd30 + 6'($past(ctrlReg[11:8])));
endmodule

// File: tb/test_gpc_unit.sv
module test_gpc_unit;
  localparam int CLK_PERIOD = 10;
  localparam int PA_W = 48;
  localparam int BASE_W = PA_W - 12;
  localparam logic [PA_W-1:0] MASK = 48'h00FF_FFFF_FFFF;
  localparam logic [PA_W-1:0] IN_ADDR = 48'h0000_0012_3000;
  localparam logic [PA_W-1:0] OUT_ADDR = 48'h0100_0000_0000;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqValid = 1'b0;
  logic [PA_W-1:0] reqAddr = '0;
  logic [1:0] reqSpace = '0;
  logic [1:0] reqSecState = '0;
  logic [15:0] ctrlReg = '0;
  logic [BASE_W-1:0] tableBase = '0;
  logic [PA_W-1:0] ppsMask = MASK;
  logic secEl2Present = 1'b1;
  logic [3:0] gpi = '0;
  logic rspValid;
  logic [1:0] rspFault;
  logic [5:0] rspL0Size;

  int compared = 0;
  int mismatched = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  gpc_unit #(.PA_W(PA_W)) i_gpc_unit (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqAddr(reqAddr),
    .reqSpace(reqSpace), .reqSecState(reqSecState), .ctrlReg(ctrlReg),
    .tableBase(tableBase), .ppsMask(ppsMask), .secEl2Present(secEl2Present),
    .gpi(gpi), .rspValid(rspValid), .rspFault(rspFault), .rspL0Size(rspL0Size)
  );

  task automatic check(string req, int actual, int expected);
    compared++;
    if (actual != expected) begin
      mismatched++;
      $display("FAIL %s: actual %0d expected %0d", req, actual, expected);
    end
  endtask

  // Drive one request at a falling edge, sample the result one edge later.
  task automatic issue(logic [PA_W-1:0] addr, logic [1:0] sp, logic [1:0] st,
                       logic [15:0] ctl, logic [BASE_W-1:0] base,
                       logic [3:0] code, logic strap);
    @(negedge clk);
    reqValid = 1'b1; reqAddr = addr; reqSpace = sp; reqSecState = st;
    ctrlReg = ctl; tableBase = base; gpi = code; secEl2Present = strap;
    @(negedge clk);
    reqValid = 1'b0;
  endtask

  task automatic expectFault(string req, int exp);
    check(req, int'(rspValid), 1);
    check(req, int'(rspFault), exp);
  endtask

  task automatic testReset();
    check("R1 valid", int'(rspValid), 0);
    check("R1 fault", int'(rspFault), 0);
  endtask

  task automatic testDisable();
    issue(IN_ADDR, 2'd0, 2'd0, 16'h0001, '0, 4'hF, 1'b1);
    expectFault("R3 secure off", 1);
    issue(OUT_ADDR, 2'd1, 2'd1, 16'h0002, '0, 4'hF, 1'b1);
    expectFault("R3 ns off beats outside pass", 1);
    issue(IN_ADDR, 2'd3, 2'd3, 16'h0004, '0, 4'hF, 1'b1);
    expectFault("R3 realm off", 1);
    issue(IN_ADDR, 2'd2, 2'd2, 16'h0007, '0, 4'hF, 1'b1);
    expectFault("R3 root unaffected", 0);
    issue(IN_ADDR, 2'd0, 2'd0, 16'h0006, '0, 4'hF, 1'b1);
    expectFault("R3 other bits only", 0);
  endtask

  task automatic testOutside();
    issue(OUT_ADDR, 2'd1, 2'd0, 16'h0000, {BASE_W{1'b1}}, 4'h0, 1'b1);
    expectFault("R4 ns outside passes", 0);
    issue(OUT_ADDR, 2'd3, 2'd3, 16'h0000, '0, 4'hF, 1'b1);
    expectFault("R4 realm outside fails", 1);
    issue(OUT_ADDR, 2'd0, 2'd0, 16'h0008, {BASE_W{1'b1}}, 4'h0, 1'b1);
    expectFault("R4 exemption passes", 0);
    issue(OUT_ADDR, 2'd2, 2'd2, 16'h0000, {BASE_W{1'b1}}, 4'h0, 1'b1);
    expectFault("R4 root outside fails over size", 1);
  endtask

  task automatic testBase();
    issue(IN_ADDR, 2'd1, 2'd1, 16'h0000, 36'h1_0000_0000, 4'hF, 1'b1);
    expectFault("R5 base outside", 2);
    issue(IN_ADDR, 2'd1, 2'd1, 16'h0000, 36'h0_0FFF_FFFF, 4'h0, 1'b1);
    expectFault("R5 base at edge", 3);
  endtask

  task automatic testAllAccess();
    for (int s = 0; s < 4; s++) begin
      issue(IN_ADDR, 2'(s), 2'(s), 16'h0000, '0, 4'hF, 1'b1);
      expectFault("R6 all access", 0);
    end
  endtask

  task automatic testMatch();
    for (int c = 8; c < 12; c++) begin
      for (int s = 0; s < 4; s++) begin
        issue(IN_ADDR, 2'(s), 2'(s), 16'h0000, '0, 4'(c), 1'b1);
        expectFault("R7 space match", (s == c - 8) ? 0 : 1);
      end
    end
  endtask

  task automatic testSecStrap();
    issue(IN_ADDR, 2'd0, 2'd0, 16'h0000, '0, 4'b1000, 1'b0);
    expectFault("R8 no strap", 3);
    issue(IN_ADDR, 2'd1, 2'd1, 16'h0000, '0, 4'b1000, 1'b0);
    expectFault("R8 no strap mismatch", 3);
    issue(IN_ADDR, 2'd1, 2'd1, 16'h0000, '0, 4'b1001, 1'b0);
    expectFault("R8 ns code unaffected", 0);
  endtask

  task automatic testNsOnly();
    issue(IN_ADDR, 2'd1, 2'd1, 16'h0000, '0, 4'b1101, 1'b1);
    expectFault("R9 disabled", 3);
    issue(IN_ADDR, 2'd1, 2'd1, 16'h0010, '0, 4'b1101, 1'b1);
    expectFault("R9 ns from ns", 0);
    issue(IN_ADDR, 2'd1, 2'd2, 16'h0010, '0, 4'b1101, 1'b1);
    expectFault("R9 ns from root", 0);
    issue(IN_ADDR, 2'd1, 2'd0, 16'h0010, '0, 4'b1101, 1'b1);
    expectFault("R9 ns from secure", 1);
    issue(IN_ADDR, 2'd1, 2'd3, 16'h0010, '0, 4'b1101, 1'b1);
    expectFault("R9 ns from realm", 1);
    issue(IN_ADDR, 2'd2, 2'd2, 16'h0010, '0, 4'b1101, 1'b1);
    expectFault("R9 root target", 1);
  endtask

  task automatic testReserved();
    for (int c = 0; c < 16; c++) begin
      if (c == 15 || (c >= 8 && c <= 11) || c == 13) continue;
      issue(IN_ADDR, 2'd1, 2'd1, 16'h0010, '0, 4'(c), 1'b1);
      expectFault("R10 reserved", 3);
    end
  endtask

  task automatic testL0();
    issue(IN_ADDR, 2'd1, 2'd1, 16'h0000, '0, 4'hF, 1'b1);
    check("R11 field 0", int'(rspL0Size), 30);
    issue(IN_ADDR, 2'd1, 2'd1, 16'h0F00, '0, 4'hF, 1'b1);
    check("R11 field 15", int'(rspL0Size), 45);
    issue(IN_ADDR, 2'd1, 2'd1, 16'h0600, '0, 4'hF, 1'b1);
    check("R11 field 6", int'(rspL0Size), 36);
  endtask

  task automatic testHold();
    issue(IN_ADDR, 2'd1, 2'd1, 16'h0300, 36'h1_0000_0000, 4'hF, 1'b1);
    expectFault("R2 setup", 2);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      gpi = 4'h0; tableBase = '0; ctrlReg = 16'h0F01; reqSpace = 2'd0;
      check("R2 idle valid", int'(rspValid), 0);
      check("R2 held fault", int'(rspFault), 2);
      check("R2 held size", int'(rspL0Size), 33);
    end
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      compared++;
      mismatched++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    repeat (2) @(negedge clk);
    testReset();
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testDisable();
    testOutside();
    testBase();
    testAllAccess();
    testMatch();
    testSecStrap();
    testNsOnly();
    testReserved();
    testL0();
    testHold();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule